// File: doc/BRIEF.md
# Load-Store Queue with Store-to-Load Forwarding

This block keeps the in-flight memory operations of an out-of-order core in program order, one slot per operation. Operations take slots in order at allocation. Execution units later fill in each slot's address, and each store's data, through two update ports. When a load is asked to issue, the queue decides whether it may go ahead. Any older store whose address is still unknown holds it back, which is the conservative approach to memory ordering. If the load may proceed, the queue looks for the closest older store to the same word address and returns that store's data. When no older store matches, the load reads the data cache instead.

Stores reach the cache only when the head slot commits, so a wrong-path store never changes architected memory. A flush port names a sequence number and drops every entry younger than it. The requester then re-allocates along the correct path. Load responses come back through a fixed three-edge pipeline, so a new load can issue every cycle. The cache is modelled as a read port with one cycle of latency plus a write port.

Top module: `mem_order_queue`

## Requirements
- R1: After reset the queue is empty: `alloc_ready` is 1, `alloc_slot` is 0, and `ld_resp_valid`, `cache_rd_en` and `cache_wr_en` are all 0.
- R2: An accepted allocation takes slot `alloc_slot`, and the next allocation gets the following slot, modulo DEPTH. While DEPTH entries are held, `alloc_ready` is 0, an allocation request is ignored and `alloc_slot` does not move. A commit frees one slot.
- R3: A load request whose load has any older store without a known address is answered with `ld_resp_retry`=1 and issues no cache read.
- R4: When older stores with a known address match the load's address exactly, the load takes the data of the youngest of them. It answers with `ld_resp_fwd`=1 and `ld_resp_retry`=0 and issues no cache read.
- R5: When the youngest matching older store has no data yet, the load is answered with retry and the cache is not read.
- R6: When no older store matches, the cycle after the request edge shows `cache_rd_en`=1 with `cache_rd_addr` set to the load address. The response carries the cache data with `ld_resp_fwd`=0.
- R7: Stores younger than the load, and older stores to other addresses, do not affect the load's result. This holds even when their data is missing.
- R8: On a commit, a store at the head drives `cache_wr_en`=1 with its address and data in the next cycle. A load at the head writes nothing. No other event writes the cache.
- R9: A flush removes every entry whose sequence number is younger than `flush_seq`, using wrap-around (signed difference) comparison, so the next slot handed out is the one after the last kept entry. In a flush cycle, allocation and commit requests are ignored.
- R10: A load request naming a slot that is empty, holds a store, or holds a load without an address is answered with retry.
- R11: A request sampled at clock edge k produces its response, tagged with the requested slot, in the cycle after edge k+2. Requests may be presented on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Allocate one entry this cycle |
| alloc_store | input | 1 | 1 = store, 0 = load |
| alloc_seq | input | SEQW | Sequence number of the new entry |
| alloc_ready | output | 1 | Queue has a free slot |
| alloc_slot | output | log2(DEPTH) | Slot the next allocation takes |
| addr_valid | input | 1 | Address update strobe |
| addr_slot | input | log2(DEPTH) | Slot receiving the address |
| addr_value | input | AW | Word address |
| data_valid | input | 1 | Store data update strobe |
| data_slot | input | log2(DEPTH) | Slot receiving the data |
| data_value | input | DW | Store data |
| ld_req | input | 1 | Load issue request |
| ld_slot | input | log2(DEPTH) | Slot of the requesting load |
| ld_resp_valid | output | 1 | Load response present |
| ld_resp_retry | output | 1 | Load refused, request again later |
| ld_resp_fwd | output | 1 | Data came from an older store |
| ld_resp_slot | output | log2(DEPTH) | Slot the response belongs to |
| ld_resp_data | output | DW | Load data |
| cache_rd_en | output | 1 | Cache read request |
| cache_rd_addr | output | AW | Cache read address |
| cache_rd_data | input | DW | Cache read data, one cycle after the request |
| cache_wr_en | output | 1 | Cache write for a committed store |
| cache_wr_addr | output | AW | Cache write address |
| cache_wr_data | output | DW | Cache write data |
| commit_valid | input | 1 | Retire the head entry |
| flush_valid | input | 1 | Drop entries younger than flush_seq |
| flush_seq | input | SEQW | Sequence number of the last entry kept |

## Verification
The bench builds the queue with DEPTH=8, so the full condition and the wrap of the slot index are reached after a handful of allocations. SEQW=4 lets a flush between sequence numbers 15 and 0 exercise the wrap-around age comparison. AW=8 and DW=16 keep the bench's cache model a small closed-form function of the address plus one overlay for the last committed write. A table of two-store-plus-load arrangements covers the forwarding, blocking and cache cases.

// File: rtl/mem_order_pkg.sv
package mem_order_pkg;
  // Outcome of a load issue decision, carried down the response pipeline.
  typedef enum logic [1:0] {
    RSP_NONE  = 2'd0,
    RSP_CACHE = 2'd1,
    RSP_FWD   = 2'd2,
    RSP_RETRY = 2'd3
  } rsp_kind_e;
endpackage

// File: rtl/lsq_ring_ctrl.sv
module lsq_ring_ctrl #(
  parameter int DEPTH = 16,
  localparam int SW = $clog2(DEPTH),
  localparam int CW = SW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          alloc_fire,
  input  logic          commit_fire,
  input  logic          flush_fire,
  input  logic [CW-1:0] drop_cnt,
  output logic [SW-1:0] head,
  output logic [SW-1:0] tail,
  output logic [CW-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else if (flush_fire) begin
      // younger entries form a suffix, so the tail simply retreats
      tail  <= tail - SW'(drop_cnt);
      count <= count - drop_cnt;
    end else begin
      if (alloc_fire)  tail <= tail + 1'b1;
      if (commit_fire) head <= head + 1'b1;
      count <= count + CW'(alloc_fire) - CW'(commit_fire);
    end
  end
endmodule

// File: rtl/lsq_search.sv
module lsq_search #(
  parameter int DEPTH = 16,
  parameter int AW    = 32,
  localparam int SW = $clog2(DEPTH)
) (
  input  logic [SW-1:0]             head,
  input  logic [SW-1:0]             ld_slot,
  input  logic [AW-1:0]             ld_addr,
  input  logic [DEPTH-1:0]          is_store,
  input  logic [DEPTH-1:0]          addr_known,
  input  logic [DEPTH-1:0][AW-1:0]  addr,
  output logic                      blocked,
  output logic                      hit,
  output logic [SW-1:0]             hit_slot
);
  logic [SW-1:0] span;
  logic [SW-1:0] pos;

  // Walk from the youngest older position back towards the head; the first
  // known-address store to the same word wins.
  always_comb begin
    span     = ld_slot - head;
    blocked  = 1'b0;
    hit      = 1'b0;
    hit_slot = '0;
    pos      = '0;
    for (int p = DEPTH - 1; p >= 0; p--) begin
      pos = head + SW'(p);
      if (SW'(p) < span && is_store[pos]) begin
        if (!addr_known[pos]) begin
          blocked = 1'b1;
        end else if (!hit && addr[pos] == ld_addr) begin
          hit      = 1'b1;
          hit_slot = pos;
        end
      end
    end
  end
endmodule

// File: rtl/lsq_resp_pipe.sv
module lsq_resp_pipe
  import mem_order_pkg::*;
#(
  parameter int SW = 4,
  parameter int DW = 32
) (
  input  logic      clk,
  input  logic      rst,
  input  rsp_kind_e in_kind,
  input  logic [SW-1:0] in_slot,
  input  logic [DW-1:0] in_data,
  input  logic [DW-1:0] cache_data,
  output logic          out_valid,
  output logic          out_retry,
  output logic          out_fwd,
  output logic [SW-1:0] out_slot,
  output logic [DW-1:0] out_data
);
  rsp_kind_e     k_a, k_b;
  logic [SW-1:0] s_a, s_b;
  logic [DW-1:0] d_a, d_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      k_a       <= RSP_NONE;
      k_b       <= RSP_NONE;
      out_valid <= 1'b0;
      out_retry <= 1'b0;
      out_fwd   <= 1'b0;
    end else begin
      k_a       <= in_kind;
      k_b       <= k_a;
      out_valid <= (k_b != RSP_NONE);
      out_retry <= (k_b == RSP_RETRY);
      out_fwd   <= (k_b == RSP_FWD);
    end
  end

  // payload registers carry no reset
  always_ff @(posedge clk) begin
    s_a      <= in_slot;
    s_b      <= s_a;
    d_a      <= in_data;
    d_b      <= d_a;
    out_slot <= s_b;
    out_data <= (k_b == RSP_CACHE) ? cache_data : d_b;
  end
endmodule

// File: rtl/mem_order_queue.sv
module mem_order_queue
  import mem_order_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int SEQW  = 8,
  localparam int SW = $clog2(DEPTH),
  localparam int CW = SW + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            alloc_valid,
  input  logic            alloc_store,
  input  logic [SEQW-1:0] alloc_seq,
  output logic            alloc_ready,
  output logic [SW-1:0]   alloc_slot,
  input  logic            addr_valid,
  input  logic [SW-1:0]   addr_slot,
  input  logic [AW-1:0]   addr_value,
  input  logic            data_valid,
  input  logic [SW-1:0]   data_slot,
  input  logic [DW-1:0]   data_value,
  input  logic            ld_req,
  input  logic [SW-1:0]   ld_slot,
  output logic            ld_resp_valid,
  output logic            ld_resp_retry,
  output logic            ld_resp_fwd,
  output logic [SW-1:0]   ld_resp_slot,
  output logic [DW-1:0]   ld_resp_data,
  output logic            cache_rd_en,
  output logic [AW-1:0]   cache_rd_addr,
  input  logic [DW-1:0]   cache_rd_data,
  output logic            cache_wr_en,
  output logic [AW-1:0]   cache_wr_addr,
  output logic [DW-1:0]   cache_wr_data,
  input  logic            commit_valid,
  input  logic            flush_valid,
  input  logic [SEQW-1:0] flush_seq
);
  // entry state
  logic [DEPTH-1:0]           e_vld, e_st, e_aok, e_dok;
  logic [DEPTH-1:0][AW-1:0]   e_addr;
  logic [DEPTH-1:0][DW-1:0]   e_data;
  logic [DEPTH-1:0][SEQW-1:0] e_seq;

  logic [SW-1:0] q_head, q_tail;
  logic [CW-1:0] q_count;
  logic          alloc_fire, commit_fire;
  logic [DEPTH-1:0] young;
  logic [CW-1:0] drop_cnt;

  assign alloc_ready = (q_count != CW'(DEPTH));
  assign alloc_slot  = q_tail;
  assign alloc_fire  = alloc_valid && alloc_ready && !flush_valid;
  assign commit_fire = commit_valid && (q_count != '0) && !flush_valid;

  // age test against the flush point, wrap-around safe
  for (genvar i = 0; i < DEPTH; i++) begin : g_age
    logic [SEQW-1:0] diff;
    assign diff     = e_seq[i] - flush_seq;
    assign young[i] = e_vld[i] && !diff[SEQW-1] && (diff != '0);
  end
  assign drop_cnt = CW'($countones(young));

  lsq_ring_ctrl #(.DEPTH(DEPTH)) u_ring (
    .clk        (clk),
    .rst        (rst),
    .alloc_fire (alloc_fire),
    .commit_fire(commit_fire),
    .flush_fire (flush_valid),
    .drop_cnt   (drop_cnt),
    .head       (q_head),
    .tail       (q_tail),
    .count      (q_count)
  );

  // control bits with reset
  always_ff @(posedge clk) begin
    if (rst) begin
      e_vld <= '0;
      e_st  <= '0;
      e_aok <= '0;
      e_dok <= '0;
    end else begin
      if (addr_valid) e_aok[addr_slot] <= 1'b1;
      if (data_valid) e_dok[data_slot] <= 1'b1;
      if (flush_valid) begin
        e_vld <= e_vld & ~young;
      end else begin
        if (commit_fire) e_vld[q_head] <= 1'b0;
        if (alloc_fire) begin
          e_vld[q_tail] <= 1'b1;
          e_st[q_tail]  <= alloc_store;
          e_aok[q_tail] <= 1'b0;
          e_dok[q_tail] <= 1'b0;
        end
      end
    end
  end

  // payload fields, no reset
  always_ff @(posedge clk) begin
    if (alloc_fire) e_seq[q_tail]     <= alloc_seq;
    if (addr_valid) e_addr[addr_slot] <= addr_value;
    if (data_valid) e_data[data_slot] <= data_value;
  end

  // load issue decision
  logic          srch_blocked, srch_hit;
  logic [SW-1:0] srch_slot;
  logic          ld_ok;
  rsp_kind_e     ld_kind;

  lsq_search #(.DEPTH(DEPTH), .AW(AW)) u_search (
    .head      (q_head),
    .ld_slot   (ld_slot),
    .ld_addr   (e_addr[ld_slot]),
    .is_store  (e_st),
    .addr_known(e_aok),
    .addr      (e_addr),
    .blocked   (srch_blocked),
    .hit       (srch_hit),
    .hit_slot  (srch_slot)
  );

  assign ld_ok = e_vld[ld_slot] && !e_st[ld_slot] && e_aok[ld_slot];

  always_comb begin
    if (!ld_req)
      ld_kind = RSP_NONE;
    else if (!ld_ok || srch_blocked || (srch_hit && !e_dok[srch_slot]))
      ld_kind = RSP_RETRY;
    else if (srch_hit)
      ld_kind = RSP_FWD;
    else
      ld_kind = RSP_CACHE;
  end

  lsq_resp_pipe #(.SW(SW), .DW(DW)) u_resp (
    .clk       (clk),
    .rst       (rst),
    .in_kind   (ld_kind),
    .in_slot   (ld_slot),
    .in_data   (e_data[srch_slot]),
    .cache_data(cache_rd_data),
    .out_valid (ld_resp_valid),
    .out_retry (ld_resp_retry),
    .out_fwd   (ld_resp_fwd),
    .out_slot  (ld_resp_slot),
    .out_data  (ld_resp_data)
  );

  // cache ports
  always_ff @(posedge clk) begin
    if (rst) begin
      cache_rd_en <= 1'b0;
      cache_wr_en <= 1'b0;
    end else begin
      cache_rd_en <= (ld_kind == RSP_CACHE);
      cache_wr_en <= commit_fire && e_st[q_head];
    end
  end

  always_ff @(posedge clk) begin
    cache_rd_addr <= e_addr[ld_slot];
    cache_wr_addr <= e_addr[q_head];
    cache_wr_data <= e_data[q_head];
  end
endmodule

// File: rtl/mem_order_queue_chk.sv
module mem_order_queue_chk #(
  parameter int SW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          alloc_valid,
  input logic          alloc_ready,
  input logic [SW-1:0] alloc_slot,
  input logic          flush_valid,
  input logic          commit_valid,
  input logic          ld_req,
  input logic          cache_rd_en,
  input logic          cache_wr_en,
  input logic          ld_resp_valid,
  input logic          ld_resp_fwd,
  input logic          ld_resp_retry
);
  // R2: an accepted allocation advances the next slot by one
  a_r2_tail_step: assert property (@(posedge clk) disable iff (rst)
    (alloc_valid && alloc_ready && !flush_valid) |=> (alloc_slot == SW'($past(alloc_slot) + 1'b1)));

  // R3: a response is never both refused and forwarded
  a_r3_kind_excl: assert property (@(posedge clk) disable iff (rst)
    ld_resp_valid |-> !(ld_resp_fwd && ld_resp_retry));

  // R4: a forwarded response had no cache read behind it
  a_r4_fwd_skips_cache: assert property (@(posedge clk) disable iff (rst)
    (ld_resp_valid && ld_resp_fwd) |-> !$past(cache_rd_en, 2));

  // R6: a cache read only follows a load request
  a_r6_read_needs_req: assert property (@(posedge clk) disable iff (rst)
    cache_rd_en |-> $past(ld_req));

  // R8: a cache write only follows a commit outside a flush
  a_r8_write_needs_commit: assert property (@(posedge clk) disable iff (rst)
    cache_wr_en |-> $past(commit_valid && !flush_valid));

  // R9: a flush cycle retires nothing
  a_r9_flush_holds_write: assert property (@(posedge clk) disable iff (rst)
    flush_valid |=> !cache_wr_en);

  // R11: responses arrive a fixed distance after a request
  a_r11_resp_latency: assert property (@(posedge clk) disable iff (rst)
    ld_resp_valid |-> $past(ld_req, 3));
endmodule

bind mem_order_queue mem_order_queue_chk #(.SW(SW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .alloc_valid  (alloc_valid),
  .alloc_ready  (alloc_ready),
  .alloc_slot   (alloc_slot),
  .flush_valid  (flush_valid),
  .commit_valid (commit_valid),
  .ld_req       (ld_req),
  .cache_rd_en  (cache_rd_en),
  .cache_wr_en  (cache_wr_en),
  .ld_resp_valid(ld_resp_valid),
  .ld_resp_fwd  (ld_resp_fwd),
  .ld_resp_retry(ld_resp_retry)
);

// File: tb/mem_order_queue_test.sv
module mem_order_queue_test;
  localparam int DEPTH = 8;
  localparam int AW    = 8;
  localparam int DW    = 16;
  localparam int SEQW  = 4;
  localparam int SW    = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic            alloc_valid = 0, alloc_store = 0;
  logic [SEQW-1:0] alloc_seq = '0;
  logic            alloc_ready;
  logic [SW-1:0]   alloc_slot;
  logic            addr_valid = 0;
  logic [SW-1:0]   addr_slot = '0;
  logic [AW-1:0]   addr_value = '0;
  logic            data_valid = 0;
  logic [SW-1:0]   data_slot = '0;
  logic [DW-1:0]   data_value = '0;
  logic            ld_req = 0;
  logic [SW-1:0]   ld_slot = '0;
  logic            ld_resp_valid, ld_resp_retry, ld_resp_fwd;
  logic [SW-1:0]   ld_resp_slot;
  logic [DW-1:0]   ld_resp_data;
  logic            cache_rd_en;
  logic [AW-1:0]   cache_rd_addr;
  logic [DW-1:0]   cache_rd_data;
  logic            cache_wr_en;
  logic [AW-1:0]   cache_wr_addr;
  logic [DW-1:0]   cache_wr_data;
  logic            commit_valid = 0;
  logic            flush_valid = 0;
  logic [SEQW-1:0] flush_seq = '0;

  mem_order_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .SEQW(SEQW)) uut (
    .clk(clk), .rst(rst),
    .alloc_valid(alloc_valid), .alloc_store(alloc_store), .alloc_seq(alloc_seq),
    .alloc_ready(alloc_ready), .alloc_slot(alloc_slot),
    .addr_valid(addr_valid), .addr_slot(addr_slot), .addr_value(addr_value),
    .data_valid(data_valid), .data_slot(data_slot), .data_value(data_value),
    .ld_req(ld_req), .ld_slot(ld_slot),
    .ld_resp_valid(ld_resp_valid), .ld_resp_retry(ld_resp_retry), .ld_resp_fwd(ld_resp_fwd),
    .ld_resp_slot(ld_resp_slot), .ld_resp_data(ld_resp_data),
    .cache_rd_en(cache_rd_en), .cache_rd_addr(cache_rd_addr), .cache_rd_data(cache_rd_data),
    .cache_wr_en(cache_wr_en), .cache_wr_addr(cache_wr_addr), .cache_wr_data(cache_wr_data),
    .commit_valid(commit_valid), .flush_valid(flush_valid), .flush_seq(flush_seq)
  );

  // cache model: closed-form contents plus the last committed write
  logic          wr_seen;
  logic [AW-1:0] wr_a;
  logic [DW-1:0] wr_d;
  always_ff @(posedge clk) begin
    if (rst) wr_seen <= 1'b0;
    else if (cache_wr_en) begin
      wr_seen <= 1'b1;
      wr_a    <= cache_wr_addr;
      wr_d    <= cache_wr_data;
    end
    if (cache_rd_en)
      cache_rd_data <= (wr_seen && wr_a == cache_rd_addr) ? wr_d : {8'hC0, cache_rd_addr};
  end

  function automatic logic [DW-1:0] mem_val(input logic [AW-1:0] a);
    return {8'hC0, a};
  endfunction

  int n_chk = 0;
  int n_err = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic reset_dut();
    rst = 1'b1;
    step();
    step();
    rst = 1'b0;
  endtask

  task automatic alloc(input logic st, input logic [SEQW-1:0] sq, output logic [SW-1:0] s);
    alloc_valid = 1'b1; alloc_store = st; alloc_seq = sq;
    s = alloc_slot;
    step();
    alloc_valid = 1'b0;
  endtask

  task automatic set_addr(input logic [SW-1:0] s, input logic [AW-1:0] a);
    addr_valid = 1'b1; addr_slot = s; addr_value = a;
    step();
    addr_valid = 1'b0;
  endtask

  task automatic set_data(input logic [SW-1:0] s, input logic [DW-1:0] d);
    data_valid = 1'b1; data_slot = s; data_value = d;
    step();
    data_valid = 1'b0;
  endtask

  task automatic commit();
    commit_valid = 1'b1;
    step();
    commit_valid = 1'b0;
  endtask

  task automatic do_load(input logic [SW-1:0] s, output logic rd, output logic [AW-1:0] ra,
                         output logic rv, output logic rr, output logic rf,
                         output logic [SW-1:0] rs, output logic [DW-1:0] rdat);
    ld_req = 1'b1; ld_slot = s;
    step();
    rd = cache_rd_en; ra = cache_rd_addr;
    ld_req = 1'b0;
    step();
    step();
    rv = ld_resp_valid; rr = ld_resp_retry; rf = ld_resp_fwd;
    rs = ld_resp_slot; rdat = ld_resp_data;
  endtask

  // vector: {store0 addr, store0 addr known, store1 addr, store1 addr known,
  //          store1 data ready, load addr, kind (0 cache,1 fwd,2 retry), src (0 store0,1 store1)}
  localparam logic [29:0] VEC [8] = '{
    {8'h10, 1'b1, 8'h20, 1'b1, 1'b1, 8'h30, 2'd0, 1'b0},  // R6 no match
    {8'h10, 1'b1, 8'h20, 1'b1, 1'b1, 8'h10, 2'd1, 1'b0},  // R4 older of two
    {8'h10, 1'b1, 8'h10, 1'b1, 1'b1, 8'h10, 2'd1, 1'b1},  // R4 youngest match wins
    {8'h10, 1'b1, 8'h10, 1'b1, 1'b0, 8'h10, 2'd2, 1'b0},  // R5 match lacks data
    {8'h10, 1'b0, 8'h20, 1'b1, 1'b1, 8'h20, 2'd2, 1'b0},  // R3 oldest address unknown
    {8'h10, 1'b1, 8'h20, 1'b0, 1'b1, 8'h10, 2'd2, 1'b0},  // R3 nearer address unknown
    {8'h10, 1'b1, 8'h20, 1'b1, 1'b0, 8'h10, 2'd1, 1'b0},  // R7 other-address store w/o data
    {8'h20, 1'b1, 8'h10, 1'b1, 1'b1, 8'h20, 2'd1, 1'b0}   // R4 match behind non-match
  };

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [SW-1:0] s;
    logic rd, rv, rr, rf;
    logic [AW-1:0] ra;
    logic [SW-1:0] rs;
    logic [DW-1:0] rdat;

    @(negedge clk);
    reset_dut();

    // R1 reset state
    chk("R1 alloc_ready", alloc_ready, 1);
    chk("R1 alloc_slot", alloc_slot, 0);
    chk("R1 resp idle", ld_resp_valid, 0);
    chk("R1 rd idle", cache_rd_en, 0);
    chk("R1 wr idle", cache_wr_en, 0);

    // table of forwarding arrangements
    for (int v = 0; v < 8; v++) begin
      logic [29:0] w;
      string tag;
      logic [DW-1:0] exp_d;
      w = VEC[v];
      tag = (w[2:1] == 2'd0) ? "R6" : (w[2:1] == 2'd1) ? "R4" : "R3/R5";
      reset_dut();
      alloc(1'b1, 4'd1, s);
      alloc(1'b1, 4'd2, s);
      alloc(1'b0, 4'd3, s);
      if (w[21]) set_addr(3'd0, w[29:22]);
      set_data(3'd0, 16'hA000);
      if (w[12]) set_addr(3'd1, w[20:13]);
      if (w[11]) set_data(3'd1, 16'hB000);
      set_addr(3'd2, w[10:3]);
      do_load(3'd2, rd, ra, rv, rr, rf, rs, rdat);
      chk({tag, " valid"}, rv, 1);
      chk({tag, " slot"}, rs, 2);
      case (w[2:1])
        2'd0: begin
          chk("R6 rd_en", rd, 1);
          chk("R6 rd_addr", ra, w[10:3]);
          chk("R6 fwd", rf, 0);
          chk("R6 retry", rr, 0);
          chk("R6 data", rdat, mem_val(w[10:3]));
        end
        2'd1: begin
          exp_d = w[0] ? 16'hB000 : 16'hA000;
          chk("R4 rd_en", rd, 0);
          chk("R4 fwd", rf, 1);
          chk("R4 retry", rr, 0);
          chk("R4/R7 data", rdat, exp_d);
        end
        default: begin
          chk("R3/R5 rd_en", rd, 0);
          chk("R3/R5 retry", rr, 1);
        end
      endcase
    end

    // R2 fill, full, ignored alloc, commit frees
    reset_dut();
    for (int i = 0; i < DEPTH; i++) begin
      alloc(1'b0, SEQW'(i), s);
      chk("R2 slot order", s, i);
    end
    chk("R2 full ready", alloc_ready, 0);
    alloc_valid = 1'b1;
    step();
    alloc_valid = 1'b0;
    chk("R2 ignored alloc slot", alloc_slot, 0);
    chk("R2 ignored alloc ready", alloc_ready, 0);
    commit();
    chk("R8 load commit no write", cache_wr_en, 0);
    chk("R2 ready after commit", alloc_ready, 1);

    // R10 invalid load requests
    reset_dut();
    alloc(1'b1, 4'd1, s);
    set_addr(3'd0, 8'h44);
    set_data(3'd0, 16'h4444);
    alloc(1'b0, 4'd2, s);
    do_load(3'd0, rd, ra, rv, rr, rf, rs, rdat);
    chk("R10 store slot retry", rr, 1);
    do_load(3'd1, rd, ra, rv, rr, rf, rs, rdat);
    chk("R10 no address retry", rr, 1);
    do_load(3'd5, rd, ra, rv, rr, rf, rs, rdat);
    chk("R10 empty slot retry", rr, 1);
    chk("R10 empty slot no read", rd, 0);

    // R7 younger store ignored
    reset_dut();
    alloc(1'b0, 4'd1, s);
    set_addr(3'd0, 8'h22);
    alloc(1'b1, 4'd2, s);
    set_addr(3'd1, 8'h22);
    set_data(3'd1, 16'h5555);
    do_load(3'd0, rd, ra, rv, rr, rf, rs, rdat);
    chk("R7 younger store fwd", rf, 0);
    chk("R7 younger store data", rdat, mem_val(8'h22));

    // R8 store commit writes cache
    reset_dut();
    alloc(1'b1, 4'd1, s);
    set_addr(3'd0, 8'h40);
    set_data(3'd0, 16'h1234);
    chk("R8 no write before commit", cache_wr_en, 0);
    commit();
    chk("R8 wr_en", cache_wr_en, 1);
    chk("R8 wr_addr", cache_wr_addr, 8'h40);
    chk("R8 wr_data", cache_wr_data, 16'h1234);
    alloc(1'b0, 4'd2, s);
    set_addr(s, 8'h40);
    do_load(s, rd, ra, rv, rr, rf, rs, rdat);
    chk("R8 committed data visible", rdat, 16'h1234);

    // R9 flush across sequence wrap, alloc and commit ignored
    reset_dut();
    alloc(1'b1, 4'd14, s);
    set_addr(3'd0, 8'h31);
    set_data(3'd0, 16'h1111);
    alloc(1'b1, 4'd15, s);
    alloc(1'b1, 4'd0, s);
    alloc(1'b0, 4'd1, s);
    flush_valid = 1'b1; flush_seq = 4'd15;
    alloc_valid = 1'b1; alloc_seq = 4'd2; commit_valid = 1'b1;
    step();
    flush_valid = 1'b0; alloc_valid = 1'b0; commit_valid = 1'b0;
    chk("R9 next slot after flush", alloc_slot, 2);
    chk("R9 commit ignored", cache_wr_en, 0);
    commit();
    chk("R9 head kept", cache_wr_addr, 8'h31);
    chk("R9 head store writes", cache_wr_en, 1);

    // R11 back-to-back requests
    reset_dut();
    alloc(1'b1, 4'd1, s);
    set_addr(3'd0, 8'h50);
    set_data(3'd0, 16'hAAAA);
    alloc(1'b0, 4'd2, s);
    set_addr(3'd1, 8'h50);
    alloc(1'b0, 4'd3, s);
    set_addr(3'd2, 8'h60);
    ld_req = 1'b1; ld_slot = 3'd1;
    step();
    ld_slot = 3'd2;
    step();
    ld_req = 1'b0;
    step();
    chk("R11 first valid", ld_resp_valid, 1);
    chk("R11 first slot", ld_resp_slot, 1);
    chk("R11 first data", ld_resp_data, 16'hAAAA);
    step();
    chk("R11 second valid", ld_resp_valid, 1);
    chk("R11 second slot", ld_resp_slot, 2);
    chk("R11 second data", ld_resp_data, mem_val(8'h60));
    step();
    chk("R11 idle after", ld_resp_valid, 0);

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule